// File: doc/BRIEF.md
# Streaming Ones-Complement Checksum Unit

This block produces 16-bit ones-complement checksums for packet headers in two independent ways. The streaming path accepts one 32-bit beat per clock, each with a per-byte enable, and sums its 16-bit words into a 32-bit partial-sum register. When the beat marked as final is accepted, the block folds the carries back into 16 bits, inverts the result and presents it with a one-cycle strobe. The register then clears, so the next packet can start on the very next cycle.

The adjustment path avoids rereading a packet when a forwarding stage rewrites a few 16-bit header fields. It loads the checksum the packet already carries, then takes one old/new field pair per cycle. Each old value is removed by adding its bitwise inverse, and each new value is added. On the finish strobe, the block emits the corrected checksum with end-around carries folded in.

Top module: `csum_unit`

## Requirements
- R1: While reset is asserted and after it is released, both result buses read 0x0000 and both strobes are low until the first completed operation.
- R2: For each accepted beat, `s_data[31:16]` and `s_data[15:0]` are 16-bit words whose first byte is the high byte. `stream_result` is the bitwise inverse of the end-around-carry sum of all words in the packet.
- R3: `s_keep[3]`, `s_keep[2]`, `s_keep[1]` and `s_keep[0]` enable bytes `s_data[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. A disabled byte counts as zero, so a trailing odd byte becomes a high byte with a zero low byte. A final beat with no enabled byte yields 0xFFFF when it is the only beat.
- R4: The result is registered on the clock edge that accepts the final beat. `stream_result_valid` is then high for exactly that one cycle. The partial sum clears, so back-to-back packets are independent.
- R5: Beats presented while `s_valid` is low are not summed.
- R6: `stream_result` keeps its value between packet completions.
- R7: Carries out of bit 15 are folded back in, whatever their number. Several all-ones beats give 0x0000.
- R8: After `inc_load` with checksum C and pairs (old, new) presented with `inc_field_valid`, the `inc_finish` strobe yields ~(~C + ~old1 + new1 + ...) in ones-complement arithmetic.
- R9: A load in the same cycle as a field pair uses the loaded checksum as the base. A field pair in the same cycle as the finish strobe is included in that result. A load and a finish with no pair return C unchanged.
- R10: `adj_result_valid` is high for exactly the one cycle after each `inc_finish`, and `adj_result` holds otherwise. Field pairs without a finish do not change the output.
- R11: Swapping the two bytes of every 16-bit word of a packet swaps the two bytes of the streaming result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Beat present this cycle |
| s_data | input | 32 | Beat data, first byte in bits 31:24 |
| s_keep | input | 4 | Per-byte enable |
| s_last | input | 1 | Final beat of packet |
| inc_load | input | 1 | Load original checksum |
| inc_orig | input | 16 | Original checksum value |
| inc_field_valid | input | 1 | Field pair present |
| inc_old | input | 16 | Field value before rewrite |
| inc_new | input | 16 | Field value after rewrite |
| inc_finish | input | 1 | Emit adjusted checksum |
| stream_result | output | 16 | Streaming checksum |
| stream_result_valid | output | 1 | One-cycle strobe for stream_result |
| adj_result | output | 16 | Adjusted checksum |
| adj_result_valid | output | 1 | One-cycle strobe for adj_result |

## Verification
The streaming sum is driven with multi-beat header-like packets, all-ones beats, partial-enable final beats and a beat with no enabled byte. These patterns separate a wrong word order, a wrong byte mask and a missing or single-pass carry fold. Back-to-back single-beat packets and idle beats carrying garbage show whether the partial sum clears and whether invalid beats leak in. A byte-swapped copy of a packet must give a byte-swapped result. The adjuster is run with separate load, pair and finish cycles and with all three merged. This shows whether pairs are attributed to the right base and the right finish.

// File: rtl/csum_pkg.sv
`timescale 1ns/1ps
package csum_pkg;
  localparam int unsigned CS_W  = 16;
  localparam int unsigned ACC_W = 32;

  typedef logic [CS_W-1:0]  word_t;
  typedef logic [ACC_W-1:0] acc_t;

  // two folds of upper half into lower half remove every carry
  function automatic word_t fold_acc(acc_t x);
    logic [CS_W:0] t;
    logic [CS_W:0] u;
    t = {1'b0, x[ACC_W-1:CS_W]} + {1'b0, x[CS_W-1:0]};
    u = {{CS_W{1'b0}}, t[CS_W]} + {1'b0, t[CS_W-1:0]};
    return u[CS_W-1:0];
  endfunction

  function automatic acc_t widen(word_t w);
    return {{(ACC_W-CS_W){1'b0}}, w};
  endfunction

  function automatic word_t finalize(acc_t x);
    return ~fold_acc(x);
  endfunction

  // removal of old value = addition of its inverse
  function automatic acc_t adjust_term(word_t old_v, word_t new_v);
    return widen(~old_v) + widen(new_v);
  endfunction
endpackage

// File: rtl/csum_lane_sum.sv
`timescale 1ns/1ps
module csum_lane_sum
  import csum_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]   data,
  input  logic [DATA_W/8-1:0] keep,
  output acc_t                total
);
  localparam int unsigned KEEP_W = DATA_W / 8;
  localparam int unsigned WORDS  = DATA_W / CS_W;

  logic [DATA_W-1:0] masked;

  for (genvar b = 0; b < KEEP_W; b++) begin : g_byte
    assign masked[8*b +: 8] = keep[b] ? data[8*b +: 8] : 8'h00;
  end

  always_comb begin
    total = '0;
    for (int w = 0; w < WORDS; w++) begin
      total = total + widen(masked[CS_W*w +: CS_W]);
    end
  end
endmodule

// File: rtl/csum_stream_acc.sv
`timescale 1ns/1ps
module csum_stream_acc
  import csum_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  beat_fire,
  input  logic  beat_last,
  input  acc_t  beat_total,
  output word_t result,
  output logic  result_valid
);
  acc_t acc_q;
  acc_t acc_sum;

  assign acc_sum = acc_q + beat_total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q        <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (beat_fire) begin
        if (beat_last) begin
          result       <= finalize(acc_sum);
          result_valid <= 1'b1;
          acc_q        <= '0;
        end else begin
          acc_q <= acc_sum;
        end
      end
    end
  end
endmodule

// File: rtl/csum_incr_adj.sv
`timescale 1ns/1ps
module csum_incr_adj
  import csum_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t orig,
  input  logic  field_valid,
  input  word_t old_v,
  input  word_t new_v,
  input  logic  finish,
  output word_t result,
  output logic  result_valid
);
  acc_t acc_q;
  acc_t base;
  acc_t acc_next;

  always_comb begin
    base     = load ? widen(~orig) : acc_q;
    acc_next = base + (field_valid ? adjust_term(old_v, new_v) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q        <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else if (finish) begin
      result       <= finalize(acc_next);
      result_valid <= 1'b1;
      acc_q        <= '0;
    end else begin
      acc_q        <= acc_next;
      result_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/csum_unit.sv
`timescale 1ns/1ps
module csum_unit
  import csum_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  input  logic [DATA_W-1:0]   s_data,
  input  logic [DATA_W/8-1:0] s_keep,
  input  logic                s_last,
  input  logic                inc_load,
  input  logic [15:0]         inc_orig,
  input  logic                inc_field_valid,
  input  logic [15:0]         inc_old,
  input  logic [15:0]         inc_new,
  input  logic                inc_finish,
  output logic [15:0]         stream_result,
  output logic                stream_result_valid,
  output logic [15:0]         adj_result,
  output logic                adj_result_valid
);
  // named internal events for the checker
  logic stream_close;
  logic adj_close;
  acc_t beat_total;

  assign stream_close = s_valid & s_last;
  assign adj_close    = inc_finish;

  csum_lane_sum #(.DATA_W(DATA_W)) i_lane (
    .data  (s_data),
    .keep  (s_keep),
    .total (beat_total)
  );

  csum_stream_acc i_stream (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_fire    (s_valid),
    .beat_last    (s_last),
    .beat_total   (beat_total),
    .result       (stream_result),
    .result_valid (stream_result_valid)
  );

  csum_incr_adj i_adj (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (inc_load),
    .orig         (inc_orig),
    .field_valid  (inc_field_valid),
    .old_v        (inc_old),
    .new_v        (inc_new),
    .finish       (adj_close),
    .result       (adj_result),
    .result_valid (adj_result_valid)
  );
endmodule

// File: rtl/csum_unit_sva.sv
`timescale 1ns/1ps
module csum_unit_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        s_last,
  input logic        inc_load,
  input logic [15:0] inc_orig,
  input logic        inc_field_valid,
  input logic [15:0] inc_old,
  input logic [15:0] inc_new,
  input logic        inc_finish,
  input logic [15:0] stream_result,
  input logic        stream_result_valid,
  input logic [15:0] adj_result,
  input logic        adj_result_valid,
  input logic        stream_close,
  input logic        adj_close
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!stream_result_valid && !adj_result_valid));

  p_stream_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stream_close |=> stream_result_valid);

  p_stream_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_last) |=> !stream_result_valid);

  p_stream_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_last) |=> $stable(stream_result));

  p_adj_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adj_close |=> adj_result_valid);

  p_adj_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_finish |=> (!adj_result_valid && $stable(adj_result)));

  p_adj_identity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_load && inc_finish && !inc_field_valid) |=> adj_result == $past(inc_orig));

  p_adj_noop_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_load && inc_finish && inc_field_valid && inc_old == inc_new && inc_orig != 16'hFFFF)
    |=> adj_result == $past(inc_orig));
endmodule

bind csum_unit csum_unit_sva i_sva (
  .clk                 (clk),
  .rst_n               (rst_n),
  .s_valid             (s_valid),
  .s_last              (s_last),
  .inc_load            (inc_load),
  .inc_orig            (inc_orig),
  .inc_field_valid     (inc_field_valid),
  .inc_old             (inc_old),
  .inc_new             (inc_new),
  .inc_finish          (inc_finish),
  .stream_result       (stream_result),
  .stream_result_valid (stream_result_valid),
  .adj_result          (adj_result),
  .adj_result_valid    (adj_result_valid),
  .stream_close        (stream_close),
  .adj_close           (adj_close)
);

// File: tb/test_csum_unit.sv
`timescale 1ns/1ps
module test_csum_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic [3:0]  s_keep = '0;
  logic        s_last = 1'b0;
  logic        inc_load = 1'b0;
  logic [15:0] inc_orig = '0;
  logic        inc_field_valid = 1'b0;
  logic [15:0] inc_old = '0;
  logic [15:0] inc_new = '0;
  logic        inc_finish = 1'b0;
  logic [15:0] stream_result;
  logic        stream_result_valid;
  logic [15:0] adj_result;
  logic        adj_result_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csum_unit i_csum_unit (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_keep(s_keep),
    .s_last(s_last), .inc_load(inc_load), .inc_orig(inc_orig),
    .inc_field_valid(inc_field_valid), .inc_old(inc_old), .inc_new(inc_new),
    .inc_finish(inc_finish), .stream_result(stream_result),
    .stream_result_valid(stream_result_valid), .adj_result(adj_result),
    .adj_result_valid(adj_result_valid)
  );

  typedef struct packed {
    logic        last;
    logic [3:0]  keep;
    logic [31:0] data;
  } beat_t;

  localparam int NV = 10;
  localparam beat_t VEC [NV] = '{
    '{1'b0, 4'hF, 32'h4500_0073},
    '{1'b1, 4'hF, 32'h0000_4000},
    '{1'b0, 4'hF, 32'hFFFF_FFFF},
    '{1'b0, 4'hF, 32'hFFFF_FFFF},
    '{1'b1, 4'hF, 32'hFFFF_FFFF},
    '{1'b1, 4'hE, 32'h1234_5678},
    '{1'b1, 4'h8, 32'hAABB_CCDD},
    '{1'b1, 4'h0, 32'hDEAD_BEEF},
    '{1'b0, 4'hF, 32'h0001_FFFF},
    '{1'b1, 4'hC, 32'h8000_9999}
  };

  // end-around 16-bit add, one word at a time
  function automatic logic [15:0] oc_add(logic [15:0] a, logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] beat_words(logic [15:0] run, logic [31:0] d, logic [3:0] k);
    logic [7:0] by [4];
    for (int i = 0; i < 4; i++) by[i] = k[3-i] ? d[31-8*i -: 8] : 8'h00;
    run = oc_add(run, {by[0], by[1]});
    run = oc_add(run, {by[2], by[3]});
    return run;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    s_valid = 1'b0; s_last = 1'b0; inc_load = 1'b0; inc_field_valid = 1'b0; inc_finish = 1'b0;
  endtask

  // one beat with a gap; returns after the result cycle
  task automatic send(input logic [31:0] d, input logic [3:0] k, input logic l);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_keep = k; s_last = l;
    @(negedge clk);
    s_valid = 1'b0; s_data = 32'hBAD0_BAD0; s_keep = 4'hF; s_last = 1'b1;
  endtask

  function automatic logic [15:0] ref_adj(logic [15:0] c, logic [15:0] o1, logic [15:0] n1,
                                         logic [15:0] o2, logic [15:0] n2, int npairs);
    logic [15:0] r;
    r = ~c;
    if (npairs > 0) begin r = oc_add(r, ~o1); r = oc_add(r, n1); end
    if (npairs > 1) begin r = oc_add(r, ~o2); r = oc_add(r, n2); end
    return ~r;
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] run;
    logic [15:0] r_a;
    logic [15:0] r_b;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 stream_result", stream_result, 16'h0000);
    check("R1 stream_valid", {15'd0, stream_result_valid}, 16'h0);
    check("R1 adj_result", adj_result, 16'h0000);
    check("R1 adj_valid", {15'd0, adj_result_valid}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {15'd0, stream_result_valid | adj_result_valid}, 16'h0);

    // R2 R3 R5 R7: vector table, idle cycles with garbage between beats
    run = 16'h0000;
    for (int v = 0; v < NV; v++) begin
      run = beat_words(run, VEC[v].data, VEC[v].keep);
      send(VEC[v].data, VEC[v].keep, VEC[v].last);
      if (VEC[v].last) begin
        check("R2 R3 R7 vector valid", {15'd0, stream_result_valid}, 16'h1);
        check("R2 R3 R7 vector result", stream_result, ~run);
        run = 16'h0000;
      end else begin
        check("R4 no strobe mid packet", {15'd0, stream_result_valid}, 16'h0);
      end
    end

    // R7: fixed expectations for carry fold and masking corners
    send(32'hFFFF_FFFF, 4'hF, 1'b0);
    send(32'hFFFF_FFFF, 4'hF, 1'b1);
    check("R7 all ones", stream_result, 16'h0000);
    send(32'hAB00_0000, 4'h8, 1'b1);
    check("R3 odd byte", stream_result, 16'h54FF);
    send(32'h0000_0000, 4'h0, 1'b1);
    check("R3 empty beat", stream_result, 16'hFFFF);

    // R6: result held while idle, R4 strobe one cycle
    @(negedge clk);
    check("R4 strobe width", {15'd0, stream_result_valid}, 16'h0);
    check("R6 hold", stream_result, 16'hFFFF);

    // R4: back-to-back single-beat packets
    @(negedge clk);
    s_valid = 1'b1; s_data = 32'h0102_0304; s_keep = 4'hF; s_last = 1'b1;
    @(negedge clk);
    s_data = 32'h1000_2000;
    check("R4 b2b first valid", {15'd0, stream_result_valid}, 16'h1);
    check("R4 b2b first", stream_result, ~16'h0406);
    @(negedge clk);
    idle_inputs();
    check("R4 b2b second valid", {15'd0, stream_result_valid}, 16'h1);
    check("R4 b2b second cleared", stream_result, ~16'h3000);
    @(negedge clk);
    check("R4 b2b drop", {15'd0, stream_result_valid}, 16'h0);

    // R11: byte swap symmetry
    send(32'h1122_3344, 4'hF, 1'b0);
    send(32'h5566_778F, 4'hF, 1'b1);
    r_a = stream_result;
    send(32'h2211_4433, 4'hF, 1'b0);
    send(32'h6655_8F77, 4'hF, 1'b1);
    r_b = stream_result;
    check("R11 swapped", r_b, {r_a[7:0], r_a[15:8]});
    run = beat_words(beat_words(16'h0, 32'h1122_3344, 4'hF), 32'h5566_778F, 4'hF);
    check("R11 base", r_a, ~run);

    // R8: separate load, two pairs, finish
    @(negedge clk);
    inc_load = 1'b1; inc_orig = 16'hB1E6;
    @(negedge clk);
    inc_load = 1'b0; inc_field_valid = 1'b1; inc_old = 16'h4001; inc_new = 16'h3F01;
    @(negedge clk);
    inc_old = 16'hC0A8; inc_new = 16'h0A00;
    @(negedge clk);
    inc_field_valid = 1'b0; inc_finish = 1'b1;
    @(negedge clk);
    inc_finish = 1'b0;
    check("R8 valid", {15'd0, adj_result_valid}, 16'h1);
    check("R8 result", adj_result, ref_adj(16'hB1E6, 16'h4001, 16'h3F01, 16'hC0A8, 16'h0A00, 2));
    r_a = adj_result;
    @(negedge clk);
    check("R10 strobe width", {15'd0, adj_result_valid}, 16'h0);

    // R10: pairs with no finish do not touch output
    inc_field_valid = 1'b1; inc_old = 16'h1234; inc_new = 16'hFFFF;
    @(negedge clk);
    @(negedge clk);
    inc_field_valid = 1'b0;
    check("R10 hold", adj_result, r_a);
    check("R10 no strobe", {15'd0, adj_result_valid}, 16'h0);

    // R9: load with pair, finish with pair
    inc_load = 1'b1; inc_orig = 16'h0000; inc_field_valid = 1'b1; inc_old = 16'h0005; inc_new = 16'h0009;
    @(negedge clk);
    inc_load = 1'b0; inc_finish = 1'b1; inc_old = 16'hFFFF; inc_new = 16'h0001;
    @(negedge clk);
    idle_inputs();
    check("R9 merged", adj_result, ref_adj(16'h0000, 16'h0005, 16'h0009, 16'hFFFF, 16'h0001, 2));

    // R9: load and finish only
    inc_load = 1'b1; inc_finish = 1'b1; inc_orig = 16'h7A3C;
    @(negedge clk);
    idle_inputs();
    check("R9 identity", adj_result, 16'h7A3C);
    check("R9 identity valid", {15'd0, adj_result_valid}, 16'h1);

    // R8: single pair all in one cycle
    inc_load = 1'b1; inc_finish = 1'b1; inc_orig = 16'hFFFF; inc_field_valid = 1'b1;
    inc_old = 16'h0000; inc_new = 16'hFFFE;
    @(negedge clk);
    idle_inputs();
    check("R8 one cycle", adj_result, ref_adj(16'hFFFF, 16'h0000, 16'hFFFE, 16'h0, 16'h0, 1));

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule